// File: doc/BRIEF.md
# Two-Stage Spiking Neuron Core

This block models one leaky spiking neuron with two chained leaky stages, advanced one time step for each clock cycle in which `step_en` is high. The first stage is a pair of synapse accumulators, one fed by excitatory input lines and one by inhibitory input lines. On every step each accumulator loses a fixed fraction of its value and gains the weights of those of its lines that spiked in that step. The second stage is the membrane potential. It leaks by its own fixed fraction, gains the excitatory accumulator and loses the inhibitory accumulator. Because the stages are separate, one input spike makes the membrane rise over several steps rather than jump in one.

All values are two's-complement fixed point with `FRAC` fractional bits. Resting potential is 0 and the firing threshold is 1.0. Every leak multiplier is a constant just below one, and it is built without a multiplier: the value minus at most three right-shifted copies of itself, each copy truncated toward zero. A control machine with the states ST_INTEGRATE and ST_REFRACT decides whether the membrane integrates or is held at rest. The FIRE transition (ST_INTEGRATE to ST_REFRACT) is taken when the updated potential reaches threshold. The RELEASE transition (ST_REFRACT to ST_INTEGRATE) is taken on the last step of the refractory count.

Per-line weights come in on ports as flat vectors, so the enclosing fabric can hold them in its own storage.

Top module: `spike_neuron_core`

## Requirements
- R1: While `rst_n` is low and after reset, `vmem_o` is 0, `spike_o` is 0 and both synapse accumulators are 0.
- R2: In a cycle with `step_en` low, no state changes: `vmem_o` holds, and spikes presented in that cycle never reach either accumulator.
- R3: On each step the excitatory accumulator becomes E - (|E|>>6) - (|E|>>7) - (|E|>>10), with the sign of E, plus the sum of the unsigned weights (Q0.16, line i at bits [16*i+15:16*i] of `exc_wt`) of the excitatory lines high in that step, clamped at the largest positive value.
- R4: The inhibitory accumulator follows the same rule with shifts 7, 8 and 11, using `inh_wt` and `inh_spk`, and it is subtracted from the membrane.
- R5: In ST_INTEGRATE, a step sets the membrane to V - (|V|>>8) - (|V|>>10) - (|V|>>11), with the sign of V, plus the excitatory accumulator minus the inhibitory accumulator as they stood before that step. An input spike therefore first shows on `vmem_o` one step after it arrives, and then keeps growing.
- R6: When the updated potential is at least 1.0 (raw 65536), that step sets `vmem_o` to 0 and raises `spike_o` for exactly one clock cycle (FIRE).
- R7: After FIRE, the next 50 steps hold `vmem_o` at 0 and never fire. The 50th of them takes RELEASE, and the step after it integrates again.
- R8: Input spikes arriving during the refractory steps still update the synapse accumulators, and the effect shows on `vmem_o` on the first step after RELEASE.
- R9: The membrane saturates at -2^23 and 2^23-1 (raw, 24-bit) rather than wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | Advance one time step in this cycle |
| exc_spk | input | N_EXC | Excitatory input spikes for this step |
| inh_spk | input | N_INH | Inhibitory input spikes for this step |
| exc_wt | input | N_EXC*WW | Excitatory weights, unsigned Q0.16 per line |
| inh_wt | input | N_INH*WW | Inhibitory weight magnitudes, unsigned Q0.16 per line |
| spike_o | output | 1 | One-cycle output spike |
| vmem_o | output | VW | Signed membrane potential, FRAC fractional bits |

## Verification
Two functions can fall in the same step: synapse accumulation and the membrane's FIRE or RELEASE decision. Inputs that arrive on the step that fires, or during the refractory hold, change only the synapse stage, and they must still reach the membrane on the first step after RELEASE. The bench keeps inputs asserted across FIRE and drives inhibitory lines through the whole refractory window. It then judges the first integrating step against a step-by-step model: the value must be negative and equal to the model. A sustained run of the table sequences also makes FIRE and RELEASE recur back to back, with every step compared against the model.

// File: rtl/neuron_pkg.sv
package neuron_pkg;

    // Membrane control machine states
    typedef enum logic [0:0] {
        ST_INTEGRATE = 1'b0,
        ST_REFRACT   = 1'b1
    } nrn_state_e;

endpackage

// File: rtl/shift_decay.sv
// Constant leak multiply: x * (1 - 2^-A - 2^-B - 2^-C), each term truncated
// toward zero. A shift of 0 removes that term.
module shift_decay #(
    parameter int W    = 24,
    parameter int SH_A = 8,
    parameter int SH_B = 10,
    parameter int SH_C = 11
) (
    input  logic signed [W-1:0] x,
    output logic signed [W-1:0] y
);
    localparam int SH [3] = '{SH_A, SH_B, SH_C};

    logic              neg;
    logic [W:0]        mag;
    logic signed [W:0] part [4];

    assign neg     = x[W-1];
    assign mag     = neg ? (~{x[W-1], x} + 1'b1) : {x[W-1], x};
    assign part[0] = {x[W-1], x};

    for (genvar k = 0; k < 3; k++) begin : g_term
        if (SH[k] > 0) begin : g_on
            logic signed [W:0] t;
            assign t = signed'(mag >> SH[k]);
            assign part[k+1] = neg ? (part[k] + t) : (part[k] - t);
        end else begin : g_off
            assign part[k+1] = part[k];
        end
    end

    assign y = part[3][W-1:0];
endmodule

// File: rtl/synapse_accum.sv
// One synapse accumulator: leak by a shift-add constant, add spiking weights.
module synapse_accum #(
    parameter int N    = 80,
    parameter int W    = 24,
    parameter int WW   = 16,
    parameter int SH_A = 6,
    parameter int SH_B = 7,
    parameter int SH_C = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step_en,
    input  logic [N-1:0]        spk,
    input  logic [N*WW-1:0]     wt,
    output logic signed [W-1:0] acc_q
);
    localparam int EXTW = W + $clog2(N + 1) + 1;
    localparam logic signed [EXTW-1:0] AMAX = {{(EXTW-W+1){1'b0}}, {(W-1){1'b1}}};

    logic signed [W-1:0]    leaked;
    logic signed [EXTW-1:0] wsum;
    logic signed [EXTW-1:0] nxt;

    shift_decay #(.W(W), .SH_A(SH_A), .SH_B(SH_B), .SH_C(SH_C)) u_leak (
        .x (acc_q),
        .y (leaked)
    );

    // Only lines that spiked contribute; silent lines add nothing.
    always_comb begin
        wsum = '0;
        for (int i = 0; i < N; i++) begin
            if (spk[i]) wsum = wsum + signed'({{(EXTW-WW){1'b0}}, wt[i*WW +: WW]});
        end
        nxt = signed'({{(EXTW-W){leaked[W-1]}}, leaked}) + wsum;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       acc_q <= '0;
        else if (step_en) acc_q <= (nxt > AMAX) ? AMAX[W-1:0] : nxt[W-1:0];
    end

    // R3/R4: weights are magnitudes, so an accumulator can never go negative
    assert_acc_nonneg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q >= 0);
    // R2: no step, no change
    assert_acc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(acc_q));
endmodule

// File: rtl/spike_neuron_core.sv
module spike_neuron_core #(
    parameter int N_EXC      = 80,
    parameter int N_INH      = 20,
    parameter int VW         = 24,
    parameter int FRAC       = 16,
    parameter int WW         = 16,
    parameter int REFR_STEPS = 50,
    parameter int MEM_SH_A   = 8,
    parameter int MEM_SH_B   = 10,
    parameter int MEM_SH_C   = 11,
    parameter int EXC_SH_A   = 6,
    parameter int EXC_SH_B   = 7,
    parameter int EXC_SH_C   = 10,
    parameter int INH_SH_A   = 7,
    parameter int INH_SH_B   = 8,
    parameter int INH_SH_C   = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step_en,
    input  logic [N_EXC-1:0]     exc_spk,
    input  logic [N_INH-1:0]     inh_spk,
    input  logic [N_EXC*WW-1:0]  exc_wt,
    input  logic [N_INH*WW-1:0]  inh_wt,
    output logic                 spike_o,
    output logic signed [VW-1:0] vmem_o
);
    import neuron_pkg::*;

    localparam int CW = $clog2(REFR_STEPS + 1);
    localparam logic signed [VW-1:0] THRESH = {{(VW-FRAC-1){1'b0}}, 1'b1, {FRAC{1'b0}}};
    localparam logic signed [VW+1:0] WMAX   = {3'b000, {(VW-1){1'b1}}};
    localparam logic signed [VW+1:0] WMIN   = {3'b111, {(VW-1){1'b0}}};
    localparam logic [CW-1:0]        REFR_LOAD = CW'(REFR_STEPS);

    nrn_state_e          state_q, state_d;
    logic signed [VW-1:0] exc_q, inh_q, v_q, v_leak, v_sat;
    logic signed [VW+1:0] v_wide;
    logic [CW-1:0]       cnt_q;
    logic                spike_q;
    logic                fire;

    // Synapse stage
    synapse_accum #(.N(N_EXC), .W(VW), .WW(WW),
                    .SH_A(EXC_SH_A), .SH_B(EXC_SH_B), .SH_C(EXC_SH_C)) u_exc (
        .clk, .rst_n, .step_en, .spk(exc_spk), .wt(exc_wt), .acc_q(exc_q)
    );
    synapse_accum #(.N(N_INH), .W(VW), .WW(WW),
                    .SH_A(INH_SH_A), .SH_B(INH_SH_B), .SH_C(INH_SH_C)) u_inh (
        .clk, .rst_n, .step_en, .spk(inh_spk), .wt(inh_wt), .acc_q(inh_q)
    );

    // Membrane stage arithmetic
    shift_decay #(.W(VW), .SH_A(MEM_SH_A), .SH_B(MEM_SH_B), .SH_C(MEM_SH_C)) u_mleak (
        .x (v_q),
        .y (v_leak)
    );

    always_comb begin
        v_wide = {{2{v_leak[VW-1]}}, v_leak}
               + {{2{exc_q[VW-1]}}, exc_q}
               - {{2{inh_q[VW-1]}}, inh_q};
        if (v_wide > WMAX)      v_sat = WMAX[VW-1:0];
        else if (v_wide < WMIN) v_sat = WMIN[VW-1:0];
        else                    v_sat = v_wide[VW-1:0];
    end

    // Next-state logic: FIRE and RELEASE
    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        unique case (state_q)
            ST_INTEGRATE: begin
                if (step_en && (v_sat >= THRESH)) begin
                    fire    = 1'b1;
                    state_d = ST_REFRACT;
                end
            end
            ST_REFRACT: begin
                if (step_en && (cnt_q == CW'(1))) state_d = ST_INTEGRATE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_INTEGRATE;
        else        state_q <= state_d;
    end

    // Outputs and membrane register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q     <= '0;
            spike_q <= 1'b0;
            cnt_q   <= '0;
        end else begin
            spike_q <= 1'b0;
            if (step_en) begin
                unique case (state_q)
                    ST_INTEGRATE: begin
                        if (fire) begin
                            v_q     <= '0;
                            spike_q <= 1'b1;
                            cnt_q   <= REFR_LOAD;
                        end else begin
                            v_q <= v_sat;
                        end
                    end
                    ST_REFRACT: begin
                        v_q   <= '0;
                        cnt_q <= cnt_q - 1'b1;
                    end
                endcase
            end
        end
    end

    assign spike_o = spike_q;
    assign vmem_o  = v_q;

    // R6: the output spike lasts one cycle
    assert_spike_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        spike_o |=> !spike_o);
    // R6: a spike comes with the membrane at rest
    assert_fire_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        spike_o |-> (vmem_o == '0));
    // R7: the membrane is pinned at rest while refractory
    assert_refract_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REFRACT) |-> (v_q == '0));
    // R7: the refractory counter never exceeds its load value
    assert_refract_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= REFR_LOAD);
    // R7: RELEASE only from the last refractory count
    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REFRACT && cnt_q != CW'(1)) |=> (state_q == ST_REFRACT));
    // R2: no step, no membrane or state change
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> ($stable(v_q) && $stable(state_q)));
endmodule

// File: tb/tb_spike_neuron_core.sv
`timescale 1ns/1ps
module tb_spike_neuron_core;
    localparam int NE = 80;
    localparam int NI = 20;
    localparam int WW = 16;
    localparam int VMAXI = 8388607;
    localparam int VMINI = -8388608;
    localparam int THR = 65536;

    logic              clk = 0;
    logic              rst_n = 0;
    logic              step_en = 0;
    logic [NE-1:0]     exc_spk = '0;
    logic [NI-1:0]     inh_spk = '0;
    logic [NE*WW-1:0]  exc_wt;
    logic [NI*WW-1:0]  inh_wt;
    logic              spike_o;
    logic signed [23:0] vmem_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    // reference state
    int me, mi, mv, mrefr, mspike;
    int we [NE];
    int wi [NI];

    spike_neuron_core dut (
        .clk, .rst_n, .step_en, .exc_spk, .inh_spk, .exc_wt, .inh_wt, .spike_o, .vmem_o
    );

    always #2 clk = ~clk;

    // rows: [23:16] excitatory lines active, [15:8] inhibitory lines active, [7:0] steps
    localparam logic [23:0] SEQ [6] = '{
        {8'd4,  8'd0,  8'd30},
        {8'd0,  8'd0,  8'd60},
        {8'd20, 8'd2,  8'd40},
        {8'd80, 8'd0,  8'd70},
        {8'd0,  8'd20, 8'd20},
        {8'd10, 8'd5,  8'd70}
    };

    function automatic int leak(int x, int a, int b, int c);
        int m = (x < 0) ? -x : x;
        int s = (m >> a) + (m >> b) + (m >> c);
        return (x < 0) ? x + s : x - s;
    endfunction

    function automatic int clampv(int x, int lo, int hi);
        return (x > hi) ? hi : ((x < lo) ? lo : x);
    endfunction

    task automatic model_step(int ne, int ni);
        int se = 0;
        int si = 0;
        int vn;
        for (int k = 0; k < ne; k++) se += we[k];
        for (int k = 0; k < ni; k++) si += wi[k];
        vn = clampv(leak(mv, 8, 10, 11) + me - mi, VMINI, VMAXI);
        mspike = 0;
        if (mrefr > 0) begin
            mv = 0;
            mrefr--;
        end else if (vn >= THR) begin
            mv = 0;
            mspike = 1;
            mrefr = 50;
        end else begin
            mv = vn;
        end
        me = clampv(leak(me, 6, 7, 10) + se, 0, VMAXI);
        mi = clampv(leak(mi, 7, 8, 11) + si, 0, VMAXI);
    endtask

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_weights(int escale, int iscale);
        for (int k = 0; k < NE; k++) begin
            we[k] = (escale == 0) ? 65535 : (2048 + k * 16);
            exc_wt[k*WW +: WW] = WW'(we[k]);
        end
        for (int k = 0; k < NI; k++) begin
            wi[k] = (iscale == 0) ? 65535 : (4096 + k * 64);
            inh_wt[k*WW +: WW] = WW'(wi[k]);
        end
    endtask

    task automatic do_step(int ne, int ni, bit en);
        @(negedge clk);
        for (int k = 0; k < NE; k++) exc_spk[k] = (k < ne);
        for (int k = 0; k < NI; k++) inh_spk[k] = (k < ni);
        step_en = en;
        @(negedge clk);
        step_en = 0;
        exc_spk = '0;
        inh_spk = '0;
        if (en) model_step(ne, ni);
    endtask

    task automatic check_step();
        string tag;
        if (mspike != 0)     tag = "R6 fire";
        else if (mrefr > 0)  tag = "R7 refractory";
        else                 tag = "R5 integrate";
        chk(tag, int'(vmem_o), mv);
        chk(tag, int'(spike_o), mspike);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (3) @(negedge clk);
        chk("R1 vmem in reset", int'(vmem_o), 0);
        chk("R1 spike in reset", int'(spike_o), 0);
        rst_n = 1;
        me = 0; mi = 0; mv = 0; mrefr = 0; mspike = 0;
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int w0;
        int guard;
        set_weights(1, 1);
        do_reset();
        @(negedge clk);
        chk("R1 vmem after reset", int'(vmem_o), 0);
        chk("R1 spike after reset", int'(spike_o), 0);

        // R3/R5: single excitatory spike gives a sloped rise
        w0 = we[0];
        do_step(1, 0, 1);
        chk("R5 no same-step effect", int'(vmem_o), 0);
        do_step(0, 0, 1);
        chk("R3 first rise", int'(vmem_o), w0);
        do_step(0, 0, 1);
        chk("R3 second rise", int'(vmem_o),
            leak(w0, 8, 10, 11) + leak(w0, 6, 7, 10));

        // R4: single inhibitory spike
        do_reset();
        do_step(0, 1, 1);
        do_step(0, 0, 1);
        chk("R4 first drop", int'(vmem_o), -wi[0]);
        do_step(0, 0, 1);
        chk("R4 second drop", int'(vmem_o),
            leak(-wi[0], 8, 10, 11) - leak(wi[0], 7, 8, 11));

        // R2: spikes without step_en are ignored
        do_reset();
        do_step(3, 0, 1);
        do_step(0, 0, 1);
        for (int k = 0; k < 5; k++) begin
            do_step(80, 20, 0);
            chk("R2 hold vmem", int'(vmem_o), mv);
            chk("R2 hold spike", int'(spike_o), 0);
        end
        do_step(0, 0, 1);
        chk("R2 no leak-through", int'(vmem_o), mv);

        // Table-driven sequences, every step compared against the model
        do_reset();
        for (int r = 0; r < 6; r++) begin
            for (int s = 0; s < int'(SEQ[r][7:0]); s++) begin
                do_step(int'(SEQ[r][23:16]), int'(SEQ[r][15:8]), 1);
                check_step();
            end
        end

        // R6/R7/R8: fire, then drive inhibition through the refractory window
        do_reset();
        guard = 0;
        do
            begin
                do_step(80, 0, 1);
                check_step();
                guard++;
            end
        while (mspike == 0 && guard < 20);
        chk("R6 spike seen", int'(spike_o), 1);
        @(negedge clk);
        chk("R6 spike one cycle", int'(spike_o), 0);
        for (int k = 0; k < 50; k++) begin
            do_step(0, 20, 1);
            chk("R7 held at rest", int'(vmem_o), 0);
            chk("R7 no spike", int'(spike_o), 0);
        end
        do_step(0, 0, 1);
        chk("R8 refractory input reached membrane", int'(vmem_o < 0), 1);
        chk("R8 first integrate value", int'(vmem_o), mv);

        // R9: heavy inhibition saturates at the negative limit
        set_weights(0, 0);
        do_reset();
        for (int k = 0; k < 30; k++) do_step(0, 20, 1);
        chk("R9 negative saturation", int'(vmem_o), VMINI);
        chk("R9 model agrees", mv, VMINI);

        do_reset();
        chk("R1 final reset", int'(vmem_o), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule